// File: doc/BRIEF.md
# IOMMU Command Queue Processor

This block drains a circular queue of fixed-size commands held in system memory and executes them strictly in order. Software appends commands and publishes a tail index. The block owns the head index, fetches the entry at the head, decodes it and carries it out. The head moves forward as each command retires. The queue is a power-of-two ring of 16-byte slots starting at a programmable base address. Both indices wrap modulo the ring depth, and the ring is empty when head equals tail.

Three kinds of command are understood. A local invalidation drives a request onto the translation-cache invalidate port. A device invalidation sends one invalidation message toward a device's address-translation cache and leaves every local cache alone. A fence gives the only completion guarantee. It holds until every earlier command has been acknowledged. When its notify flag is set, it then posts one 32-bit memory write. Only after that does the head step past it.

Issuing a local or device invalidation retires its slot at once. A pair of outstanding counters, one per kind, remembers the acknowledgements still owed, and these counters are what a fence waits on. An unknown opcode or a memory error response stops the block with a sticky flag until software pulses the clear input.

Top module: `iommu_cmdq`

## Requirements
- R1: In reset, head_idx is 0, illegal_err and mem_fault are 0, and no valid output is asserted.
- R2: With q_enable high and head_idx different from tail_idx, the block reads the entry at base_addr + 16 × head_idx. When head_idx equals tail_idx, it issues no read.
- R3: Command layout: opcode in bits [7:0], flag in bit 8, segment in [23:16], requester ID in [47:32], word in [63:32], address in [127:64]. Opcode 0x01 (local invalidation) drives exactly one inv_valid handshake carrying inv_all = flag and inv_tag = word. head_idx advances when that handshake completes.
- R4: Opcode 0x02 (device invalidation) produces exactly one message with msg_rid = requester ID and msg_seg_valid = flag. msg_seg equals the segment when the flag is 1 and 0 otherwise. It causes no inv_valid request.
- R5: Opcode 0x03 (fence) does not retire, and posts no write, while any local-invalidate acknowledgement (inv_ack) or message completion (msg_done) is still owed.
- R6: A fence with the flag set issues one write of the word to the command's address. head_idx moves past the fence only after an error-free write response. A fence with the flag clear issues no write.
- R7: head_idx only ever steps by one, and it wraps from DEPTH-1 to 0.
- R8: Any other opcode sets the sticky illegal_err, leaves head_idx on the offending slot and stops fetching. A fault_clr pulse clears the flag and fetching resumes from that slot.
- R9: An error on a read or write response sets the sticky mem_fault and stops processing with head_idx unchanged. fault_clr clears the flag and the block retries.
- R10: When q_enable goes low, a command already fetched still completes, and no further entry is fetched.
- R11: At most 2^CNT_W − 1 acknowledgements of each kind are outstanding. Further issue of that kind stalls until an acknowledgement arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_enable | input | 1 | Allows fetching of new entries |
| base_addr | input | ADDR_W | Byte address of ring slot 0 |
| tail_idx | input | IDX_W | Software-written producer index |
| head_idx | output | IDX_W | Consumer index owned by the block |
| fault_clr | input | 1 | Pulse clearing both sticky flags |
| illegal_err | output | 1 | Sticky unknown-opcode flag |
| mem_fault | output | 1 | Sticky memory error flag |
| rd_req_valid | output | 1 | Entry read request valid |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_req_addr | output | ADDR_W | Entry address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | 128 | Entry contents |
| rd_rsp_err | input | 1 | Read error response |
| wr_req_valid | output | 1 | Fence notify write valid |
| wr_req_ready | input | 1 | Memory accepts the write |
| wr_req_addr | output | ADDR_W | Notify address |
| wr_req_data | output | 32 | Notify data |
| wr_rsp_valid | input | 1 | Write response strobe |
| wr_rsp_err | input | 1 | Write error response |
| inv_valid | output | 1 | Local invalidate request valid |
| inv_ready | input | 1 | Cache accepts the request |
| inv_all | output | 1 | Invalidate all entries |
| inv_tag | output | 32 | Page tag to match |
| inv_ack | input | 1 | One invalidate finished |
| msg_valid | output | 1 | Device invalidation message valid |
| msg_ready | input | 1 | Message accepted |
| msg_rid | output | 16 | Target requester ID |
| msg_seg | output | 8 | Target segment (0 when not valid) |
| msg_seg_valid | output | 1 | Segment is part of the target |
| msg_done | input | 1 | One message send finished |

## Verification
The hardest situation to reach is a fence that has already been fetched while acknowledgements are still owed, together with an issue path that has backed up against a full outstanding counter. Random acknowledgement delays rarely keep either condition alive for long. The bench therefore has a switch that withholds all acknowledgements. With it set, the bench queues invalidations past the counter limit, or places a notifying fence behind pending work. It then checks that the head stops at the expected slot with no write posted, and releases the acknowledgements. Stalling the cache's ready line while q_enable is dropped reaches the in-flight-finish case in the same way.

// File: rtl/cqp_pkg.sv
// Shared definitions for the command queue processor: command layout,
// opcode values, decoded command kinds and controller states.
// Assumes 128-bit queue entries.
package cqp_pkg;
    localparam int CMD_W       = 128;
    localparam int ENTRY_SHIFT = 4;

    localparam logic [7:0] OP_LOCAL_INV  = 8'h01;
    localparam logic [7:0] OP_DEVICE_INV = 8'h02;
    localparam logic [7:0] OP_FENCE      = 8'h03;

    localparam int FLAG_BIT = 8;
    localparam int SEG_LSB  = 16;
    localparam int RID_LSB  = 32;
    localparam int WORD_LSB = 32;
    localparam int ADDR_LSB = 64;

    typedef enum logic [1:0] {
        KIND_LOCAL,
        KIND_DEVICE,
        KIND_FENCE,
        KIND_BAD
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RDREQ,
        ST_RDWAIT,
        ST_EXEC,
        ST_LOCAL,
        ST_DEVICE,
        ST_DRAIN,
        ST_WRREQ,
        ST_WRWAIT,
        ST_HALT
    } cq_state_e;
endpackage

// File: rtl/cqp_decode.sv
// Combinational decoder for one queue entry.
// Splits the raw entry into its kind and fields; field positions come from
// the package. Assumes ADDR_W is at most 64.
module cqp_decode
    import cqp_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [CMD_W-1:0]  raw,
    output cmd_kind_e         kind,
    output logic              flag,
    output logic [31:0]       word,
    output logic [15:0]       rid,
    output logic [7:0]        seg,
    output logic [ADDR_W-1:0] addr
);
    // Map the opcode onto a command kind.
    always_comb begin
        case (raw[7:0])
            OP_LOCAL_INV:  kind = KIND_LOCAL;
            OP_DEVICE_INV: kind = KIND_DEVICE;
            OP_FENCE:      kind = KIND_FENCE;
            default:       kind = KIND_BAD;
        endcase
    end

    assign flag = raw[FLAG_BIT];
    assign seg  = raw[SEG_LSB +: 8];
    assign rid  = raw[RID_LSB +: 16];
    assign word = raw[WORD_LSB +: 32];
    assign addr = raw[ADDR_LSB +: ADDR_W];

    logic unused_mid_bits;
    assign unused_mid_bits = ^{raw[15:9], raw[31:24]};

    generate
        if (ADDR_W < 64) begin : g_addr_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^raw[CMD_W-1:ADDR_LSB+ADDR_W];
        end
    endgenerate
endmodule

// File: rtl/cqp_pending_ctr.sv
// Saturation-guarded count of acknowledgements still owed for one kind of
// issued request. Assumes the issuer never increments while full and the
// responder never acknowledges more than was issued.
module cqp_pending_ctr #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // Track issues minus acknowledgements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + ONE;
                2'b01:   cnt_q <= cnt_q - ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign full = &cnt_q;
    assign zero = (cnt_q == '0);

    // R11
    ctr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !full);

    // R5
    ctr_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> !zero);
endmodule

// File: rtl/cqp_ring_ptr.sv
// Head index of the command ring and the byte address of the slot it names.
// Assumes DEPTH is a power of two so the index wraps by overflow.
module cqp_ring_ptr
    import cqp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] slot_addr
);
    logic [IDX_W-1:0] idx_q;

    // Step the head by one slot on each retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx       = idx_q;
    assign slot_addr = base_addr + (ADDR_W'(idx_q) << ENTRY_SHIFT);

    // R7
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_q) |-> idx_q == $past(idx_q) + IDX_W'(1));
endmodule

// File: rtl/iommu_cmdq.sv
// Command queue processor: fetches 16-byte entries from a memory ring,
// executes local invalidations, device invalidation messages and fences in
// order, and owns the head index. Assumes software never lets the ring hold
// more than DEPTH-1 entries and that each inv_ack / msg_done answers one
// earlier accepted request.
module iommu_cmdq
    import cqp_pkg::*;
#(
    parameter  int ADDR_W = 48,
    parameter  int DEPTH  = 64,
    parameter  int CNT_W  = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  tail_idx,
    output logic [IDX_W-1:0]  head_idx,
    input  logic              fault_clr,
    output logic              illegal_err,
    output logic              mem_fault,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    output logic              rd_rsp_ready,
    input  logic [CMD_W-1:0]  rd_rsp_data,
    input  logic              rd_rsp_err,
    output logic              wr_req_valid,
    input  logic              wr_req_ready,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [31:0]       wr_req_data,
    input  logic              wr_rsp_valid,
    input  logic              wr_rsp_err,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic              inv_all,
    output logic [31:0]       inv_tag,
    input  logic              inv_ack,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [15:0]       msg_rid,
    output logic [7:0]        msg_seg,
    output logic              msg_seg_valid,
    input  logic              msg_done
);
    cq_state_e         state_q, state_d;
    logic [CMD_W-1:0]  cmd_q;
    logic              illegal_q, mfault_q;
    logic              advance, load_cmd, set_illegal, set_mfault;
    logic [ADDR_W-1:0] slot_addr;
    logic              inv_full, inv_zero, msg_full, msg_zero;
    logic              inv_hs, msg_hs, drained, start_ok;

    cmd_kind_e         c_kind;
    logic              c_flag;
    logic [31:0]       c_word;
    logic [15:0]       c_rid;
    logic [7:0]        c_seg;
    logic [ADDR_W-1:0] c_addr;

    cqp_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .base_addr (base_addr),
        .idx       (head_idx),
        .slot_addr (slot_addr)
    );

    cqp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .raw  (cmd_q),
        .kind (c_kind),
        .flag (c_flag),
        .word (c_word),
        .rid  (c_rid),
        .seg  (c_seg),
        .addr (c_addr)
    );

    cqp_pending_ctr #(.W(CNT_W)) u_inv_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inv_hs),
        .dec   (inv_ack),
        .full  (inv_full),
        .zero  (inv_zero)
    );

    cqp_pending_ctr #(.W(CNT_W)) u_msg_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (msg_hs),
        .dec   (msg_done),
        .full  (msg_full),
        .zero  (msg_zero)
    );

    assign inv_hs   = inv_valid && inv_ready;
    assign msg_hs   = msg_valid && msg_ready;
    assign drained  = inv_zero && msg_zero;
    assign start_ok = q_enable && (head_idx != tail_idx);

    // Sequence fetch, dispatch, drain and notify for one entry at a time.
    always_comb begin
        state_d     = state_q;
        advance     = 1'b0;
        load_cmd    = 1'b0;
        set_illegal = 1'b0;
        set_mfault  = 1'b0;
        case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_RDREQ;
            ST_RDREQ:  if (rd_req_ready) state_d = ST_RDWAIT;
            ST_RDWAIT: begin
                if (rd_rsp_valid) begin
                    if (rd_rsp_err) begin
                        set_mfault = 1'b1;
                        state_d    = ST_HALT;
                    end else begin
                        load_cmd = 1'b1;
                        state_d  = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                case (c_kind)
                    KIND_LOCAL:  state_d = ST_LOCAL;
                    KIND_DEVICE: state_d = ST_DEVICE;
                    KIND_FENCE:  state_d = ST_DRAIN;
                    default: begin
                        set_illegal = 1'b1;
                        state_d     = ST_HALT;
                    end
                endcase
            end
            ST_LOCAL: begin
                if (inv_hs) begin
                    advance = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DEVICE: begin
                if (msg_hs) begin
                    advance = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (drained) begin
                    if (c_flag) begin
                        state_d = ST_WRREQ;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WRREQ:  if (wr_req_ready) state_d = ST_WRWAIT;
            ST_WRWAIT: begin
                if (wr_rsp_valid) begin
                    if (wr_rsp_err) begin
                        set_mfault = 1'b1;
                        state_d    = ST_HALT;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HALT:   if (fault_clr) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Hold the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the fetched entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_q <= '0;
        else if (load_cmd) cmd_q <= rd_rsp_data;
    end

    // Keep the sticky fault flags until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_clr) begin
            illegal_q <= 1'b0;
            mfault_q  <= 1'b0;
        end else begin
            if (set_illegal) illegal_q <= 1'b1;
            if (set_mfault)  mfault_q  <= 1'b1;
        end
    end

    assign illegal_err   = illegal_q;
    assign mem_fault     = mfault_q;

    assign rd_req_valid  = (state_q == ST_RDREQ);
    assign rd_req_addr   = slot_addr;
    assign rd_rsp_ready  = (state_q == ST_RDWAIT);

    assign wr_req_valid  = (state_q == ST_WRREQ);
    assign wr_req_addr   = c_addr;
    assign wr_req_data   = c_word;

    assign inv_valid     = (state_q == ST_LOCAL) && !inv_full;
    assign inv_all       = c_flag;
    assign inv_tag       = c_word;

    assign msg_valid     = (state_q == ST_DEVICE) && !msg_full;
    assign msg_rid       = c_rid;
    assign msg_seg_valid = c_flag;
    assign msg_seg       = c_flag ? c_seg : 8'h00;

    // R2
    fetch_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> head_idx != tail_idx);

    // R3
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> inv_valid && $stable(inv_tag) && $stable(inv_all));

    // R4
    dev_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !inv_valid);

    // R5
    fence_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> inv_zero && msg_zero);

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && !wr_req_ready) |=> wr_req_valid && $stable(wr_req_addr)
                                            && $stable(wr_req_data));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fault || illegal_err) |=> $stable(head_idx));
endmodule

// File: tb/iommu_cmdq_test.sv
module iommu_cmdq_test;
    localparam int AW    = 32;
    localparam int DEPTH = 16;
    localparam int IW    = 4;
    localparam int CW    = 2;
    localparam logic [AW-1:0] BASE = 32'h0004_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, q_enable, fault_clr;
    logic [AW-1:0] base_addr;
    logic [IW-1:0] tail_idx, head_idx;
    logic illegal_err, mem_fault;
    logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
    logic [AW-1:0] rd_req_addr;
    logic [127:0] rd_rsp_data;
    logic wr_req_valid, wr_req_ready, wr_rsp_valid, wr_rsp_err;
    logic [AW-1:0] wr_req_addr;
    logic [31:0] wr_req_data;
    logic inv_valid, inv_ready, inv_all, inv_ack;
    logic [31:0] inv_tag;
    logic msg_valid, msg_ready, msg_seg_valid, msg_done;
    logic [15:0] msg_rid;
    logic [7:0] msg_seg;

    iommu_cmdq #(.ADDR_W(AW), .DEPTH(DEPTH), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .base_addr(base_addr),
        .tail_idx(tail_idx), .head_idx(head_idx), .fault_clr(fault_clr),
        .illegal_err(illegal_err), .mem_fault(mem_fault),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
        .rd_rsp_err(rd_rsp_err),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_req_data(wr_req_data), .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_all(inv_all), .inv_tag(inv_tag),
        .inv_ack(inv_ack),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_rid(msg_rid), .msg_seg(msg_seg),
        .msg_seg_valid(msg_seg_valid), .msg_done(msg_done)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [127:0] qmem [DEPTH];
    logic [IW-1:0] tail_sw;
    logic [32:0] exp_inv[$], obs_inv[$];
    logic [24:0] exp_msg[$], obs_msg[$];
    logic [63:0] exp_wr[$], obs_wr[$];
    bit hold_acks, inv_block;
    logic [AW-1:0] err_addr;
    int rd_count;
    int inv_owed, msg_owed;

    function automatic logic [127:0] mk_local(bit all, logic [31:0] tag);
        return {64'h0, tag, 16'h0, 7'h0, all, 8'h01};
    endfunction
    function automatic logic [127:0] mk_dev(bit sv, logic [7:0] seg, logic [15:0] rid);
        return {64'h0, 16'h0, rid, 8'h0, seg, 7'h0, sv, 8'h02};
    endfunction
    function automatic logic [127:0] mk_fence(bit nt, logic [31:0] data, logic [31:0] addr);
        return {32'h0, addr, data, 16'h0, 7'h0, nt, 8'h03};
    endfunction

    task automatic add_local(bit all, logic [31:0] tag);
        qmem[tail_sw] = mk_local(all, tag);
        exp_inv.push_back({all, tag});
        tail_sw++;
    endtask
    task automatic add_dev(bit sv, logic [7:0] seg, logic [15:0] rid);
        qmem[tail_sw] = mk_dev(sv, seg, rid);
        exp_msg.push_back({sv, (sv ? seg : 8'h00), rid});
        tail_sw++;
    endtask
    task automatic add_fence(bit nt, logic [31:0] data, logic [31:0] addr);
        qmem[tail_sw] = mk_fence(nt, data, addr);
        if (nt) exp_wr.push_back({addr, data});
        tail_sw++;
    endtask
    task automatic commit();
        @(negedge clk);
        tail_idx = tail_sw;
    endtask

    task automatic wait_head(logic [IW-1:0] target, int maxc, string req);
        int n = 0;
        while (head_idx != target && n < maxc) begin
            @(negedge clk);
            n++;
        end
        check(head_idx == target, req, "head reaches tail", head_idx, target);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic compare_logs(string req);
        check(obs_inv.size() == exp_inv.size(), req, "invalidate count", obs_inv.size(), exp_inv.size());
        for (int i = 0; i < exp_inv.size() && i < obs_inv.size(); i++)
            check(obs_inv[i] == exp_inv[i], req, "invalidate fields", obs_inv[i], exp_inv[i]);
        check(obs_msg.size() == exp_msg.size(), req, "message count", obs_msg.size(), exp_msg.size());
        for (int i = 0; i < exp_msg.size() && i < obs_msg.size(); i++)
            check(obs_msg[i] == exp_msg[i], req, "message fields", obs_msg[i], exp_msg[i]);
        check(obs_wr.size() == exp_wr.size(), req, "write count", obs_wr.size(), exp_wr.size());
        for (int i = 0; i < exp_wr.size() && i < obs_wr.size(); i++)
            check(obs_wr[i] == exp_wr[i], req, "write addr/data", obs_wr[i], exp_wr[i]);
        exp_inv.delete(); obs_inv.delete();
        exp_msg.delete(); obs_msg.delete();
        exp_wr.delete();  obs_wr.delete();
    endtask

    // Memory read responder; checks each fetch address (R2).
    initial begin
        bit rd_pend = 0;
        bit rsp_fire = 0;
        logic [AW-1:0] paddr = '0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        rd_rsp_err   = 1'b0;
        rd_req_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rsp_fire) begin
                rd_rsp_valid = 1'b0;
            end else if (rd_pend && !rd_rsp_valid) begin
                logic [AW-1:0] off;
                off = paddr - BASE;
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = qmem[off[IW+3:4]];
                rd_rsp_err   = (paddr == err_addr);
                rd_pend      = 0;
            end
            rd_req_ready = ($urandom % 3 != 0);
            if (rst_n && rd_req_valid && rd_req_ready) begin
                check(rd_req_addr == BASE + {head_idx, 4'h0}, "R2", "fetch address",
                      rd_req_addr, BASE + {head_idx, 4'h0});
                rd_count++;
                rd_pend = 1;
                paddr   = rd_req_addr;
            end
            rsp_fire = rd_rsp_valid && rd_rsp_ready;
        end
    end

    // Notify write responder.
    initial begin
        bit wr_pend = 0;
        wr_rsp_valid = 1'b0;
        wr_rsp_err   = 1'b0;
        wr_req_ready = 1'b0;
        forever begin
            @(negedge clk);
            wr_rsp_valid = 1'b0;
            if (wr_pend) begin
                wr_rsp_valid = 1'b1;
                wr_pend      = 0;
            end
            wr_req_ready = ($urandom % 3 != 0);
            if (rst_n && wr_req_valid && wr_req_ready) begin
                obs_wr.push_back({wr_req_addr, wr_req_data});
                wr_pend = 1;
            end
        end
    end

    // Local cache model: accepts requests and acknowledges later.
    initial begin
        inv_ack   = 1'b0;
        inv_ready = 1'b0;
        forever begin
            @(negedge clk);
            inv_ack = 1'b0;
            if (!hold_acks && inv_owed > 0 && ($urandom % 2 == 1)) begin
                inv_ack = 1'b1;
                inv_owed--;
            end
            inv_ready = !inv_block && ($urandom % 4 != 0);
            if (rst_n && inv_valid && inv_ready) begin
                obs_inv.push_back({inv_all, inv_tag});
                inv_owed++;
            end
        end
    end

    // Device message sink: accepts messages and signals completion later.
    initial begin
        msg_done  = 1'b0;
        msg_ready = 1'b0;
        forever begin
            @(negedge clk);
            msg_done = 1'b0;
            if (!hold_acks && msg_owed > 0 && ($urandom % 2 == 1)) begin
                msg_done = 1'b1;
                msg_owed--;
            end
            msg_ready = ($urandom % 4 != 0);
            if (rst_n && msg_valid && msg_ready) begin
                obs_msg.push_back({msg_seg_valid, msg_seg, msg_rid});
                msg_owed++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [IW-1:0] start, slot;
        int rd_snap;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; q_enable = 1'b0; fault_clr = 1'b0;
        base_addr = BASE; tail_idx = '0; tail_sw = '0;
        hold_acks = 0; inv_block = 0; err_addr = '1;
        rd_count = 0; inv_owed = 0; msg_owed = 0;
        for (int i = 0; i < DEPTH; i++) qmem[i] = '0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(head_idx == 0, "R1", "head in reset", head_idx, 0);
        check(!illegal_err && !mem_fault, "R1", "flags in reset", {illegal_err, mem_fault}, 0);
        check(!rd_req_valid && !wr_req_valid && !inv_valid && !msg_valid, "R1", "valids in reset",
              {rd_req_valid, wr_req_valid, inv_valid, msg_valid}, 0);
        rst_n = 1'b1;

        // R2 empty ring: no fetch
        q_enable = 1'b1;
        repeat (20) @(negedge clk);
        check(rd_count == 0, "R2", "reads on empty ring", rd_count, 0);

        // R3 R4 R6 directed mix
        add_local(1'b0, 32'hDEAD_0001);
        add_dev(1'b1, 8'h5A, 16'h1234);
        add_dev(1'b0, 8'hC3, 16'hBEEF);
        add_local(1'b1, 32'h0000_0000);
        add_fence(1'b0, 32'h1111_2222, 32'h0000_9000);
        add_fence(1'b1, 32'hCAFE_F00D, 32'h0000_8000);
        commit();
        wait_head(tail_sw, 2000, "R3/R4/R6");
        compare_logs("R3/R4/R6");

        // R5 fence waits for owed acknowledgements
        hold_acks = 1;
        start = head_idx;
        add_dev(1'b1, 8'h01, 16'h00AA);
        add_local(1'b0, 32'h0000_0042);
        add_fence(1'b1, 32'h5555_AAAA, 32'h0000_7000);
        commit();
        repeat (40) @(negedge clk);
        check(head_idx == start + 2, "R5", "head held at fence", head_idx, start + 2);
        check(obs_wr.size() == 0, "R5", "no write before drain", obs_wr.size(), 0);
        hold_acks = 0;
        wait_head(tail_sw, 2000, "R5");
        compare_logs("R5");

        // R11 outstanding limit stalls issue
        hold_acks = 1;
        start = head_idx;
        for (int i = 0; i < 5; i++) add_local(1'b0, 32'h100 + i);
        commit();
        repeat (40) @(negedge clk);
        check(head_idx == start + 3, "R11", "head after limit", head_idx, start + 3);
        check(obs_inv.size() == 3, "R11", "issued before stall", obs_inv.size(), 3);
        hold_acks = 0;
        wait_head(tail_sw, 2000, "R11");
        compare_logs("R11");

        // R10 enable drop lets in-flight command finish
        inv_block = 1;
        start = head_idx;
        add_local(1'b0, 32'hA000_0001);
        add_local(1'b0, 32'hA000_0002);
        commit();
        for (int n = 0; n < 200 && !inv_valid; n++) @(negedge clk);
        q_enable  = 1'b0;
        inv_block = 0;
        rd_snap   = rd_count;
        repeat (30) @(negedge clk);
        check(head_idx == start + 1, "R10", "head after disable", head_idx, start + 1);
        check(obs_inv.size() == 1, "R10", "in-flight finished", obs_inv.size(), 1);
        check(rd_count == rd_snap, "R10", "no fetch while disabled", rd_count, rd_snap);
        q_enable = 1'b1;
        wait_head(tail_sw, 2000, "R10");
        compare_logs("R10");

        // R8 illegal opcode
        slot = tail_sw;
        qmem[tail_sw] = {120'h0, 8'h7F};
        tail_sw++;
        add_local(1'b0, 32'hB000_0002);
        commit();
        repeat (30) @(negedge clk);
        check(illegal_err == 1'b1, "R8", "illegal flag", illegal_err, 1);
        check(head_idx == slot, "R8", "head on bad slot", head_idx, slot);
        rd_snap = rd_count;
        repeat (20) @(negedge clk);
        check(rd_count == rd_snap, "R8", "fetch stopped", rd_count, rd_snap);
        check(obs_inv.size() == 0, "R8", "nothing issued", obs_inv.size(), 0);
        qmem[slot] = mk_local(1'b1, 32'hB000_0001);
        exp_inv.push_front({1'b1, 32'hB000_0001});
        pulse_clear();
        check(illegal_err == 1'b0, "R8", "flag cleared", illegal_err, 0);
        wait_head(tail_sw, 2000, "R8");
        compare_logs("R8");

        // R9 memory read error
        slot = tail_sw;
        err_addr = BASE + {slot, 4'h0};
        add_dev(1'b1, 8'h77, 16'h4321);
        commit();
        repeat (30) @(negedge clk);
        check(mem_fault == 1'b1, "R9", "fault flag", mem_fault, 1);
        check(head_idx == slot, "R9", "head held", head_idx, slot);
        check(obs_msg.size() == 0, "R9", "nothing sent", obs_msg.size(), 0);
        err_addr = '1;
        pulse_clear();
        check(mem_fault == 1'b0, "R9", "fault cleared", mem_fault, 0);
        wait_head(tail_sw, 2000, "R9");
        compare_logs("R9");

        // R7 random rounds wrap the ring several times
        for (int r = 0; r < 10; r++) begin
            int n;
            n = 1 + ($urandom % 14);
            for (int k = 0; k < n; k++) begin
                case ($urandom % 3)
                    0: add_local($urandom % 2, $urandom);
                    1: add_dev($urandom % 2, $urandom, $urandom);
                    default: add_fence($urandom % 2, $urandom, $urandom & 32'hFFFF_FFFC);
                endcase
            end
            commit();
            wait_head(tail_sw, 5000, "R7");
            compare_logs("R7 random");
        end
        check(!illegal_err && !mem_fault, "R7", "no flags after random", {illegal_err, mem_fault}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule